// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This unit keeps a signed 64-bit accumulator as two 32-bit halves. Each valid operation adds a signed product to that accumulator. The product comes from one of two forms. The long form multiplies both full 32-bit operands. The word form multiplies only the sign-extended low 16 bits of each operand. When the saturation input is high, each form applies its own clamp to the sum before it is written back:

- **Long form:** the clamp acts on the high half only.
- **Word form:** an out-of-range sum is replaced by a fixed saturated pattern.

A processor pipeline uses the unit for multiply-accumulate instructions. Both halves can be read at any time. Either half can be written directly when no operation is issued. A clear input returns the whole accumulator to zero.

The unit works on one action per cycle. A combinational decoder turns the inputs into one of four named actions, and a single register process applies that action at the clock edge:

- `ACT_CLEAR`: zero both halves. This action wins over everything else.
- `ACT_MAC`: write back the clamped sum.
- `ACT_LOAD`: write whichever half (or both) has its load strobe high.
- `ACT_IDLE`: hold both halves.

The only transitions are the per-cycle choices between these four actions. Every action ends after one clock edge.

Top module: `sat_mac`

## Requirements
- R1: After reset, `acc_hi` and `acc_lo` both read zero.
- R2: When `clear` is high, both halves become zero at the next edge. This holds even if `op_valid` or a load strobe is high in the same cycle.
- R3: With `op_valid` high, `op_word`=0 and `sat_en`=0, the accumulator {acc_hi,acc_lo} becomes its old value plus the signed 64-bit product of `src_a` and `src_b`, with no clamping.
- R4: With `op_valid` high, `op_word`=1 and `sat_en`=0, the added product is the product of the signed low 16 bits of each operand. Bits 31:16 of the operands have no effect, and the 64-bit sum is written without clamping.
- R5: In the long form with `sat_en`=1, a negative 64-bit sum is written with bits 31:16 of `acc_hi` forced to ones. The other bits come from the sum unchanged.
- R6: In the long form with `sat_en`=1, a non-negative sum is written with `acc_hi` reduced to its bits 14:0; bits 31:15 become zero. `acc_lo` takes the sum's low half.
- R7: In the word form with `sat_en`=1, a sum below -2^31 writes `acc_hi`=0x00000001 and `acc_lo`=0x80000000.
- R8: In the word form with `sat_en`=1, a sum above 2^31-1 writes `acc_hi`=0x00000001 and `acc_lo`=0x7FFFFFFF.
- R9: In the word form with `sat_en`=1, a sum within [-2^31, 2^31-1] is written unchanged, including a sum that lands exactly on a limit.
- R10: When `clear` and `op_valid` are low, `hi_ld_en` writes `hi_ld_data` into `acc_hi` and `lo_ld_en` writes `lo_ld_data` into `acc_lo`. Each half is loaded independently of the other.
- R11: While `op_valid` is high, both load strobes are ignored.
- R12: With `clear`, `op_valid` and both load strobes low, both halves hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Zero the accumulator (highest priority) |
| op_valid | input | 1 | Perform a multiply-accumulate this cycle |
| op_word | input | 1 | 0 = long form (32x32), 1 = word form (16x16) |
| sat_en | input | 1 | Enable the clamp for the selected form |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| hi_ld_en | input | 1 | Load the high half directly |
| hi_ld_data | input | 32 | Value for the high half |
| lo_ld_en | input | 1 | Load the low half directly |
| lo_ld_data | input | 32 | Value for the low half |
| acc_hi | output | 32 | Accumulator high half |
| acc_lo | output | 32 | Accumulator low half |

## Verification
The word-form clamps are the hardest cases to reach. A single 16x16 product is at most 2^30 in magnitude, so an accumulator starting from zero needs several operations to leave the 32-bit range. The bench avoids this by loading both halves directly to values just inside a limit. One word operation then pushes the sum past the limit, or lands it exactly on the limit.

The long-form clamp is reached the same way. The bench preloads a high half whose sign bit and upper bits make the effect of forcing and masking visible in a single step.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_MAC   = 2'd2,
        ACT_LOAD  = 2'd3
    } act_e;

endpackage

// File: rtl/mac_product.sv
module mac_product #(
    parameter int DATA_W = 32,
    parameter int HALF_W = 16,
    localparam int ACC_W = 2 * DATA_W,
    localparam int WPROD_W = 2 * HALF_W
) (
    input  logic              word_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [ACC_W-1:0]  prod
);

    logic signed [ACC_W-1:0]   long_prod;
    logic signed [WPROD_W-1:0] word_prod;

    always_comb begin
        long_prod = $signed(opnd_a) * $signed(opnd_b);
        word_prod = $signed(opnd_a[HALF_W-1:0]) * $signed(opnd_b[HALF_W-1:0]);
        if (word_mode) begin
            prod = {{(ACC_W-WPROD_W){word_prod[WPROD_W-1]}}, word_prod};
        end else begin
            prod = long_prod;
        end
    end

endmodule

// File: rtl/mac_saturate.sv
module mac_saturate #(
    parameter int DATA_W    = 32,
    parameter int FORCE_W   = 16,
    parameter int LONG_KEEP = 15,
    localparam int ACC_W    = 2 * DATA_W
) (
    input  logic              sat_en,
    input  logic              word_mode,
    input  logic [ACC_W-1:0]  sum,
    output logic [DATA_W-1:0] res_hi,
    output logic [DATA_W-1:0] res_lo
);

    localparam logic [DATA_W-1:0] FORCE_ONES = {{FORCE_W{1'b1}}, {(DATA_W-FORCE_W){1'b0}}};
    localparam logic [DATA_W-1:0] KEEP_MASK  = {{(DATA_W-LONG_KEEP){1'b0}}, {LONG_KEEP{1'b1}}};
    localparam logic [DATA_W-1:0] WSAT_HI    = DATA_W'(1);
    localparam logic [DATA_W-1:0] WSAT_MAX   = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] WSAT_MIN   = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0]  sum_hi;
    logic [DATA_W-1:0]  sum_lo;
    logic [DATA_W:0]    top_bits;
    logic               neg;
    logic               over_pos;
    logic               over_neg;

    always_comb begin
        sum_hi   = sum[ACC_W-1:DATA_W];
        sum_lo   = sum[DATA_W-1:0];
        neg      = sum[ACC_W-1];
        top_bits = sum[ACC_W-1:DATA_W-1];
        over_pos = !neg && (top_bits != '0);
        over_neg = neg && (top_bits != '1);
        res_hi   = sum_hi;
        res_lo   = sum_lo;
        if (sat_en) begin
            if (word_mode) begin
                if (over_neg) begin
                    res_hi = WSAT_HI;
                    res_lo = WSAT_MIN;
                end else if (over_pos) begin
                    res_hi = WSAT_HI;
                    res_lo = WSAT_MAX;
                end
            end else begin
                if (neg) res_hi = sum_hi | FORCE_ONES;
                else     res_hi = sum_hi & KEEP_MASK;
            end
        end
    end

endmodule

// File: rtl/sat_mac.sv
module sat_mac #(
    parameter int DATA_W    = 32,
    parameter int HALF_W    = 16,
    parameter int LONG_KEEP = 15,
    localparam int ACC_W    = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              op_valid,
    input  logic              op_word,
    input  logic              sat_en,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              hi_ld_en,
    input  logic [DATA_W-1:0] hi_ld_data,
    input  logic              lo_ld_en,
    input  logic [DATA_W-1:0] lo_ld_data,
    output logic [DATA_W-1:0] acc_hi,
    output logic [DATA_W-1:0] acc_lo
);

    import sat_mac_pkg::*;

    act_e              act;
    logic [DATA_W-1:0] hi_q, lo_q, hi_d, lo_d;
    logic [ACC_W-1:0]  prod;
    logic [ACC_W-1:0]  sum;
    logic [DATA_W-1:0] sat_hi, sat_lo;

    mac_product #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_prod (
        .word_mode (op_word),
        .opnd_a    (src_a),
        .opnd_b    (src_b),
        .prod      (prod)
    );

    assign sum = {hi_q, lo_q} + prod;

    mac_saturate #(.DATA_W(DATA_W), .FORCE_W(HALF_W), .LONG_KEEP(LONG_KEEP)) u_sat (
        .sat_en    (sat_en),
        .word_mode (op_word),
        .sum       (sum),
        .res_hi    (sat_hi),
        .res_lo    (sat_lo)
    );

    // Action decode: clear > operation > load > idle
    always_comb begin
        if (clear)                      act = ACT_CLEAR;
        else if (op_valid)              act = ACT_MAC;
        else if (hi_ld_en || lo_ld_en)  act = ACT_LOAD;
        else                            act = ACT_IDLE;
    end

    always_comb begin
        hi_d = hi_q;
        lo_d = lo_q;
        unique case (act)
            ACT_CLEAR: begin
                hi_d = '0;
                lo_d = '0;
            end
            ACT_MAC: begin
                hi_d = sat_hi;
                lo_d = sat_lo;
            end
            ACT_LOAD: begin
                if (hi_ld_en) hi_d = hi_ld_data;
                if (lo_ld_en) lo_d = lo_ld_data;
            end
            ACT_IDLE: begin
                hi_d = hi_q;
                lo_d = lo_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    assign acc_hi = hi_q;
    assign acc_lo = lo_q;

    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_hi == '0 && acc_lo == '0));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !op_valid && !hi_ld_en && !lo_ld_en) |=> ($stable(acc_hi) && $stable(acc_lo)));

    // R5 and R6: a clamped long result has either its upper 16 bits all ones or bits 31:15 all zero
    p_long_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && op_valid && !op_word && sat_en) |=>
            (acc_hi[DATA_W-1:DATA_W-HALF_W] == '1 || acc_hi[DATA_W-1:LONG_KEEP] == '0));

    // R7, R8, R9: a clamped word result leaves the high half as 0, 1 or all ones
    p_word_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && op_valid && op_word && sat_en) |=>
            (acc_hi == '0 || acc_hi == '1 || acc_hi == DATA_W'(1)));

    p_load_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !op_valid && hi_ld_en) |=> (acc_hi == $past(hi_ld_data)));

    p_load_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !op_valid && lo_ld_en) |=> (acc_lo == $past(lo_ld_data)));

endmodule

// File: tb/sat_mac_tb.sv
module sat_mac_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0, op_valid = 1'b0, op_word = 1'b0, sat_en = 1'b0;
    logic [31:0] src_a = '0, src_b = '0;
    logic        hi_ld_en = 1'b0, lo_ld_en = 1'b0;
    logic [31:0] hi_ld_data = '0, lo_ld_data = '0;
    logic [31:0] acc_hi, acc_lo;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sat_mac u_dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .op_valid(op_valid),
        .op_word(op_word), .sat_en(sat_en), .src_a(src_a), .src_b(src_b),
        .hi_ld_en(hi_ld_en), .hi_ld_data(hi_ld_data),
        .lo_ld_en(lo_ld_en), .lo_ld_data(lo_ld_data),
        .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    task automatic step();
        @(posedge clk);
        #1;
        clear = 0; op_valid = 0; op_word = 0; sat_en = 0;
        hi_ld_en = 0; lo_ld_en = 0;
    endtask

    task automatic check(input string tag, input logic [31:0] eh, input logic [31:0] el);
        n_chk++;
        if (acc_hi !== eh || acc_lo !== el) begin
            n_bad++;
            $display("FAIL %s: got %08h_%08h expected %08h_%08h", tag, acc_hi, acc_lo, eh, el);
        end
    endtask

    task automatic load(input logic [31:0] h, input logic [31:0] l);
        hi_ld_en = 1; hi_ld_data = h; lo_ld_en = 1; lo_ld_data = l;
        step();
    endtask

    task automatic mac(input logic w, input logic s, input logic [31:0] a, input logic [31:0] b);
        op_valid = 1; op_word = w; sat_en = s; src_a = a; src_b = b;
        step();
    endtask

    task automatic t_reset();
        check("R1 reset", 32'h0, 32'h0);
    endtask

    task automatic t_long_plain();
        mac(0, 0, 32'hFFFF_FFFD, 32'd7);
        check("R3 -3*7", 32'hFFFF_FFFF, 32'hFFFF_FFEB);
        mac(0, 0, 32'h4000_0000, 32'h4000_0000);
        check("R3 +2^60", 32'h0FFF_FFFF, 32'hFFFF_FFEB);
    endtask

    task automatic t_word_plain();
        load(32'h0, 32'h0);
        mac(1, 0, 32'h1234_FFFE, 32'hABCD_0003);
        check("R4 upper bits ignored", 32'hFFFF_FFFF, 32'hFFFF_FFFA);
        load(32'h0000_0001, 32'h0);
        mac(1, 0, 32'h1, 32'h1);
        check("R4 no clamp when sat off", 32'h0000_0001, 32'h0000_0001);
    endtask

    task automatic t_long_sat();
        load(32'h8000_0000, 32'h0);
        mac(0, 1, 32'h1, 32'h1);
        check("R5 negative force", 32'hFFFF_0000, 32'h0000_0001);
        load(32'h1234_F678, 32'h5);
        mac(0, 1, 32'h2, 32'h3);
        check("R6 positive mask", 32'h0000_7678, 32'h0000_000B);
    endtask

    task automatic t_word_sat();
        load(32'h0, 32'h7FFF_FF00);
        mac(1, 1, 32'h100, 32'h100);
        check("R8 above max", 32'h0000_0001, 32'h7FFF_FFFF);
        load(32'hFFFF_FFFF, 32'h8000_0010);
        mac(1, 1, 32'h0000_FFFF, 32'h20);
        check("R7 below min", 32'h0000_0001, 32'h8000_0000);
        load(32'h0, 32'h7FFF_FFFE);
        mac(1, 1, 32'h1, 32'h1);
        check("R9 exactly max", 32'h0, 32'h7FFF_FFFF);
        load(32'hFFFF_FFFF, 32'h8000_0001);
        mac(1, 1, 32'h0000_FFFF, 32'h1);
        check("R9 exactly min", 32'hFFFF_FFFF, 32'h8000_0000);
        load(32'h0, 32'h0);
        mac(1, 1, 32'h5, 32'h6);
        check("R9 small", 32'h0, 32'd30);
    endtask

    task automatic t_clear();
        load(32'hDEAD_BEEF, 32'hCAFE_F00D);
        clear = 1; op_valid = 1; src_a = 32'h5; src_b = 32'h5;
        hi_ld_en = 1; hi_ld_data = 32'h1; lo_ld_en = 1; lo_ld_data = 32'h2;
        step();
        check("R2 clear wins", 32'h0, 32'h0);
    endtask

    task automatic t_loads();
        lo_ld_en = 1; lo_ld_data = 32'h1357_9BDF;
        step();
        check("R10 low only", 32'h0, 32'h1357_9BDF);
        hi_ld_en = 1; hi_ld_data = 32'h2468_ACE0;
        step();
        check("R10 high only", 32'h2468_ACE0, 32'h1357_9BDF);
        load(32'h0, 32'h0);
        op_valid = 1; src_a = 32'h2; src_b = 32'h2;
        hi_ld_en = 1; hi_ld_data = 32'hDEAD; lo_ld_en = 1; lo_ld_data = 32'hBEEF;
        step();
        check("R11 load ignored", 32'h0, 32'h4);
        src_a = 32'h77; hi_ld_data = 32'h99;
        step();
        step();
        check("R12 idle hold", 32'h0, 32'h4);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_long_plain();
        t_word_plain();
        t_long_sat();
        t_word_sat();
        t_clear();
        t_loads();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule